// File: doc/BRIEF.md
# Double-Buffered Transmit Commit Controller

This block controls one transmit message buffer pair inside a slot-based serial bus controller. The pair has a host-facing commit side, which software fills and marks as committed, and an engine-facing transmit side, which the frame engine reads when its slot arrives. Committed data does not move: the hand-off exchanges the two buffer index pointers, so the data RAM only ever sees a new index on each side.

The host drives single-cycle commands that disable, enable, lock or unlock the commit side, set its commit flag, or clear its interrupt flag. The bus engine drives one-cycle strobes for transmission slot start, static slot start, dynamic slot start and "transmitted". A level mode input picks streaming commit (a committed message waits until the previous one has been sent at least once) or immediate commit (a committed message takes over as soon as the transmit side is not being sent). When events coincide, fixed priorities decide.

Top module: `tx_commit_ctrl`

## Requirements
- R1: The commit flag `c_cmt` is set by command COMMIT (code 1) only while `host_st` is 1 (disabled), 2 (disabled and locked) or 3 (locked); a COMMIT in state 0 (idle) or during a transfer is ignored.
- R2: Command codes are 2 DISABLE, 3 ENABLE, 4 LOCK, 5 UNLOCK. From idle, DISABLE gives 1 and LOCK gives 3; from 1, ENABLE gives 0 and LOCK gives 2; from 3, UNLOCK gives 0 and DISABLE gives 2; from 2, UNLOCK gives 1 and ENABLE gives 3.
- R3: A transfer starts in a cycle where `host_st` is 0, `c_cmt` is 1, no transfer is running, `tx_busy` is 0 and the mode allows it; `xfer_busy` is then 1 for exactly one cycle, after which `c_idx` and `t_idx` hold each other's former values.
- R4: When the swap completes, in the same edge `c_cmt` clears, `c_irq` sets, `t_cmt` sets and `t_sent` clears.
- R5: With `mode_imm` = 0, no transfer starts while `t_cmt` is 1 and `t_sent` is 0.
- R6: With `mode_imm` = 1, a transfer starts even when the transmit-side message was never sent, but never while `tx_busy` is 1.
- R7: A DISABLE or LOCK command in the cycle a transfer starts is dropped; `host_st` is unchanged.
- R8: A transmission slot start in the cycle a transfer starts is ignored: `tx_busy` stays 0.
- R9: A transmission slot start with `t_cmt` = 1 sets `tx_busy`, also when a static or dynamic slot start arrives in the same cycle; a static or dynamic slot start alone ends an active window without marking it sent.
- R10: A transmitted strobe while `tx_busy` is 1 clears `tx_busy` and sets `t_sent`.
- R11: Command IRQ_CLR (code 6) clears `c_irq`; a swap completing in the same cycle keeps it set.
- R12: After reset `c_idx` = C_IDX_INIT (2), `t_idx` = T_IDX_INIT (5), `host_st` = 0 and all flags, `xfer_busy` and `tx_busy` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_cmd | input | 3 | Host command code, 0 = none |
| mode_imm | input | 1 | 1 = immediate commit, 0 = streaming commit |
| slot_tx | input | 1 | Transmission slot start strobe |
| slot_static | input | 1 | Static slot start strobe |
| slot_dyn | input | 1 | Dynamic slot start strobe |
| tx_done | input | 1 | Transmitted strobe from the frame engine |
| c_idx | output | IDX_W | Buffer index of the commit side |
| t_idx | output | IDX_W | Buffer index of the transmit side |
| c_cmt | output | 1 | Commit-side commit flag |
| c_irq | output | 1 | Commit-side interrupt flag |
| t_cmt | output | 1 | Transmit side holds a message |
| t_sent | output | 1 | Transmit-side message sent at least once |
| host_st | output | 2 | Host state status |
| xfer_busy | output | 1 | Transfer in progress |
| tx_busy | output | 1 | Transmit side being sent |

## Verification
The hardest situations to reach are the coincidences: a transfer start landing in exactly the cycle a lock, disable or slot start arrives, and a swap completing in the cycle an interrupt clear arrives. The stimulus reaches them by walking the host through lock, commit and unlock, so the transfer start cycle is known one cycle ahead, and then placing the competing strobe in that cycle. Streaming hold-off is reached by committing a second message while the first still sits unsent on the transmit side.

// File: rtl/txc_pkg.sv
package txc_pkg;

    typedef enum logic [2:0] {
        CMD_NONE    = 3'd0,
        CMD_COMMIT  = 3'd1,
        CMD_DISABLE = 3'd2,
        CMD_ENABLE  = 3'd3,
        CMD_LOCK    = 3'd4,
        CMD_UNLOCK  = 3'd5,
        CMD_IRQCLR  = 3'd6
    } host_cmd_e;

    typedef enum logic [1:0] {
        HS_IDLE   = 2'd0,
        HS_DIS    = 2'd1,
        HS_DISLCK = 2'd2,
        HS_LCK    = 2'd3
    } host_st_e;

    // host states in which a commit request is accepted
    function automatic logic commit_allowed(host_st_e st);
        return (st == HS_DIS) || (st == HS_DISLCK) || (st == HS_LCK);
    endfunction

    function automatic host_st_e next_host(host_st_e st, host_cmd_e cmd);
        host_st_e n;
        n = st;
        unique case (st)
            HS_IDLE:   if (cmd == CMD_DISABLE) n = HS_DIS;
                       else if (cmd == CMD_LOCK) n = HS_LCK;
            HS_DIS:    if (cmd == CMD_ENABLE) n = HS_IDLE;
                       else if (cmd == CMD_LOCK) n = HS_DISLCK;
            HS_LCK:    if (cmd == CMD_UNLOCK) n = HS_IDLE;
                       else if (cmd == CMD_DISABLE) n = HS_DISLCK;
            HS_DISLCK: if (cmd == CMD_UNLOCK) n = HS_DIS;
                       else if (cmd == CMD_ENABLE) n = HS_LCK;
            default:   n = HS_IDLE;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/txc_host_fsm.sv
module txc_host_fsm
    import txc_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  host_cmd_e cmd,
    input  logic      xfer_start,
    input  logic      xfer_active,
    output host_st_e  st
);
    host_st_e st_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= HS_IDLE;
        end else if (!xfer_start && !xfer_active) begin
            st_q <= next_host(st_q, cmd);
        end
    end

    assign st = st_q;

    // a starting transfer overrides any disable or lock in the same cycle
    assert_start_wins_R7: assert property (@(posedge clk) disable iff (rst)
        xfer_start |=> (st_q == $past(st_q)));

    assert_lock_path_R2: assert property (@(posedge clk) disable iff (rst)
        (st_q == HS_IDLE && cmd == CMD_LOCK && !xfer_start && !xfer_active)
        |=> (st_q == HS_LCK));

endmodule

// File: rtl/txc_tx_side.sv
module txc_tx_side (
    input  logic clk,
    input  logic rst,
    input  logic slot_tx,
    input  logic slot_static,
    input  logic slot_dyn,
    input  logic tx_done,
    input  logic t_cmt,
    input  logic xfer_start,
    input  logic xfer_active,
    input  logic swap_done,
    output logic busy,
    output logic sent
);
    logic busy_q, sent_q;
    logic tx_go, slot_end;

    // message available beats slot assigned: a starting transfer blocks the send
    assign tx_go    = slot_tx && t_cmt && !xfer_start && !xfer_active;
    // transmission slot start has priority over plain slot starts
    assign slot_end = (slot_static || slot_dyn) && !slot_tx;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            sent_q <= 1'b0;
        end else begin
            if (swap_done) begin
                sent_q <= 1'b0;
            end else if (busy_q && tx_done) begin
                sent_q <= 1'b1;
            end

            if (tx_go) begin
                busy_q <= 1'b1;
            end else if (busy_q && (tx_done || slot_end)) begin
                busy_q <= 1'b0;
            end
        end
    end

    assign busy = busy_q;
    assign sent = sent_q;

    assert_xfer_beats_slot_R8: assert property (@(posedge clk) disable iff (rst)
        (xfer_start && !busy_q) |=> !busy_q);

    assert_slot_prio_R9: assert property (@(posedge clk) disable iff (rst)
        (slot_tx && t_cmt && !xfer_start && !xfer_active) |=> busy_q);

    assert_done_marks_R10: assert property (@(posedge clk) disable iff (rst)
        (tx_done && busy_q && !slot_tx) |=> (!busy_q && sent_q));

endmodule

// File: rtl/txc_xfer_ctrl.sv
module txc_xfer_ctrl
    import txc_pkg::*;
#(
    parameter int IDX_W      = 4,
    parameter int C_IDX_INIT = 2,
    parameter int T_IDX_INIT = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  host_cmd_e        cmd,
    input  host_st_e         host_st,
    input  logic             mode_imm,
    input  logic             tx_busy,
    input  logic             t_sent,
    output logic             xfer_start,
    output logic             xfer_active,
    output logic             swap_done,
    output logic             c_cmt,
    output logic             c_irq,
    output logic             t_cmt,
    output logic [IDX_W-1:0] c_idx,
    output logic [IDX_W-1:0] t_idx
);
    localparam logic [IDX_W-1:0] C_RST = IDX_W'(C_IDX_INIT);
    localparam logic [IDX_W-1:0] T_RST = IDX_W'(T_IDX_INIT);

    typedef struct packed {
        logic [IDX_W-1:0] c_idx;
        logic [IDX_W-1:0] t_idx;
        logic             c_cmt;
        logic             c_irq;
        logic             t_cmt;
        logic             xfer;
    } pair_t;

    pair_t r_q, r_d;
    logic  mode_ok;

    assign mode_ok    = mode_imm || !r_q.t_cmt || t_sent;
    assign xfer_start = !r_q.xfer && (host_st == HS_IDLE) && r_q.c_cmt
                        && !tx_busy && mode_ok;
    assign swap_done  = r_q.xfer;

    always_comb begin
        r_d = r_q;
        if (r_q.xfer) begin
            r_d.c_idx = r_q.t_idx;
            r_d.t_idx = r_q.c_idx;
            r_d.c_cmt = 1'b0;
            r_d.c_irq = 1'b1;
            r_d.t_cmt = 1'b1;
            r_d.xfer  = 1'b0;
        end else begin
            if (xfer_start) begin
                r_d.xfer = 1'b1;
            end else if (cmd == CMD_COMMIT && commit_allowed(host_st)) begin
                r_d.c_cmt = 1'b1;
            end
            if (cmd == CMD_IRQCLR) begin
                r_d.c_irq = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q <= '{c_idx: C_RST, t_idx: T_RST, c_cmt: 1'b0,
                     c_irq: 1'b0, t_cmt: 1'b0, xfer: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign xfer_active = r_q.xfer;
    assign c_cmt       = r_q.c_cmt;
    assign c_irq       = r_q.c_irq;
    assign t_cmt       = r_q.t_cmt;
    assign c_idx       = r_q.c_idx;
    assign t_idx       = r_q.t_idx;

    assert_commit_gate_R1: assert property (@(posedge clk) disable iff (rst)
        $rose(r_q.c_cmt) |-> ($past(cmd) == CMD_COMMIT && $past(host_st) != HS_IDLE));

    assert_swap_R3: assert property (@(posedge clk) disable iff (rst)
        r_q.xfer |=> (r_q.c_idx == $past(r_q.t_idx) && r_q.t_idx == $past(r_q.c_idx)
                      && !r_q.xfer));

    assert_flags_R4: assert property (@(posedge clk) disable iff (rst)
        r_q.xfer |=> (!r_q.c_cmt && r_q.c_irq && r_q.t_cmt));

    assert_stream_wait_R5: assert property (@(posedge clk) disable iff (rst)
        (!r_q.xfer && r_q.t_cmt && !t_sent && !mode_imm) |=> !r_q.xfer);

    assert_never_while_busy_R6: assert property (@(posedge clk) disable iff (rst)
        tx_busy |=> !r_q.xfer);

    assert_irq_clear_R11: assert property (@(posedge clk) disable iff (rst)
        (cmd == CMD_IRQCLR && !r_q.xfer) |=> !r_q.c_irq);

endmodule

// File: rtl/tx_commit_ctrl.sv
module tx_commit_ctrl
    import txc_pkg::*;
#(
    parameter int IDX_W      = 4,
    parameter int C_IDX_INIT = 2,
    parameter int T_IDX_INIT = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [2:0]       host_cmd,
    input  logic             mode_imm,
    input  logic             slot_tx,
    input  logic             slot_static,
    input  logic             slot_dyn,
    input  logic             tx_done,
    output logic [IDX_W-1:0] c_idx,
    output logic [IDX_W-1:0] t_idx,
    output logic             c_cmt,
    output logic             c_irq,
    output logic             t_cmt,
    output logic             t_sent,
    output logic [1:0]       host_st,
    output logic             xfer_busy,
    output logic             tx_busy
);
    host_cmd_e cmd;
    host_st_e  hst;
    logic      xfer_start, xfer_active, swap_done;

    assign cmd = host_cmd_e'(host_cmd);

    txc_host_fsm u_host (
        .clk        (clk),
        .rst        (rst),
        .cmd        (cmd),
        .xfer_start (xfer_start),
        .xfer_active(xfer_active),
        .st         (hst)
    );

    txc_xfer_ctrl #(
        .IDX_W     (IDX_W),
        .C_IDX_INIT(C_IDX_INIT),
        .T_IDX_INIT(T_IDX_INIT)
    ) u_xfer (
        .clk        (clk),
        .rst        (rst),
        .cmd        (cmd),
        .host_st    (hst),
        .mode_imm   (mode_imm),
        .tx_busy    (tx_busy),
        .t_sent     (t_sent),
        .xfer_start (xfer_start),
        .xfer_active(xfer_active),
        .swap_done  (swap_done),
        .c_cmt      (c_cmt),
        .c_irq      (c_irq),
        .t_cmt      (t_cmt),
        .c_idx      (c_idx),
        .t_idx      (t_idx)
    );

    txc_tx_side u_tx (
        .clk        (clk),
        .rst        (rst),
        .slot_tx    (slot_tx),
        .slot_static(slot_static),
        .slot_dyn   (slot_dyn),
        .tx_done    (tx_done),
        .t_cmt      (t_cmt),
        .xfer_start (xfer_start),
        .xfer_active(xfer_active),
        .swap_done  (swap_done),
        .busy       (tx_busy),
        .sent       (t_sent)
    );

    assign host_st   = hst;
    assign xfer_busy = xfer_active;

    assert_sent_cleared_R4: assert property (@(posedge clk) disable iff (rst)
        xfer_busy |=> !t_sent);

endmodule

// File: tb/tx_commit_ctrl_test.sv
module tx_commit_ctrl_test;

    logic       clk = 1'b0;
    logic       rst;
    logic [2:0] host_cmd;
    logic       mode_imm, slot_tx, slot_static, slot_dyn, tx_done;
    logic [3:0] c_idx, t_idx;
    logic       c_cmt, c_irq, t_cmt, t_sent, xfer_busy, tx_busy;
    logic [1:0] host_st;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    typedef struct {
        string      tag;
        logic [15:0] exp;
    } item_t;
    item_t sb[$];

    always #10 clk = ~clk;   // 50 MHz

    tx_commit_ctrl uut (
        .clk(clk), .rst(rst), .host_cmd(host_cmd), .mode_imm(mode_imm),
        .slot_tx(slot_tx), .slot_static(slot_static), .slot_dyn(slot_dyn),
        .tx_done(tx_done), .c_idx(c_idx), .t_idx(t_idx), .c_cmt(c_cmt),
        .c_irq(c_irq), .t_cmt(t_cmt), .t_sent(t_sent), .host_st(host_st),
        .xfer_busy(xfer_busy), .tx_busy(tx_busy)
    );

    function automatic logic [15:0] mk(int ci, int ti, bit cc, bit ci2, bit tc, bit ts,
                                       int hs, bit x, bit b);
        return {ci[3:0], ti[3:0], cc, ci2, tc, ts, hs[1:0], x, b};
    endfunction

    // one clock with the given stimulus; returns a quarter period after the edge
    task automatic op(input int cmd, input bit stx = 0, input bit sst = 0,
                      input bit sdy = 0, input bit dn = 0);
        host_cmd = cmd[2:0]; slot_tx = stx; slot_static = sst;
        slot_dyn = sdy; tx_done = dn;
        @(posedge clk);
        #5;
        host_cmd = 3'd0; slot_tx = 0; slot_static = 0; slot_dyn = 0; tx_done = 0;
    endtask

    task automatic chk(input string tag, input logic [15:0] e);
        item_t it;
        it.tag = tag; it.exp = e;
        sb.push_back(it);
    endtask

    // monitor: compares at the falling edge after the expectation was queued
    always @(negedge clk) begin
        logic [15:0] act;
        item_t it;
        act = {c_idx, t_idx, c_cmt, c_irq, t_cmt, t_sent, host_st, xfer_busy, tx_busy};
        while (sb.size() > 0) begin
            it = sb.pop_front();
            n_checks++;
            if (act !== it.exp) begin
                n_fail++;
                $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
            end
        end
    end

    initial begin
        #1_000_000;
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1; host_cmd = 0; mode_imm = 0; slot_tx = 0; slot_static = 0;
        slot_dyn = 0; tx_done = 0;
        repeat (3) @(posedge clk);
        #5 rst = 0;
        chk("R12 reset", mk(2,5,0,0,0,0,0,0,0));
        @(posedge clk); #5;

        // commit gate and first hand-off (streaming, empty transmit side)
        op(1); chk("R1 commit ignored in idle", mk(2,5,0,0,0,0,0,0,0));
        op(4); chk("R2 lock",                   mk(2,5,0,0,0,0,3,0,0));
        op(1); chk("R1 commit when locked",     mk(2,5,1,0,0,0,3,0,0));
        op(5); chk("R2 unlock",                 mk(2,5,1,0,0,0,0,0,0));
        op(0); chk("R3 transfer in progress",   mk(2,5,1,0,0,0,0,1,0));
        op(0); chk("R4 swap and flags",         mk(5,2,0,1,1,0,0,0,0));
        op(6); chk("R11 irq clear",             mk(5,2,0,0,1,0,0,0,0));

        // streaming hold-off
        op(4); op(1); op(5);
        chk("R1 second commit",                 mk(5,2,1,0,1,0,0,0,0));
        for (int i = 0; i < 3; i++) begin
            op(0); chk("R5 streaming waits",    mk(5,2,1,0,1,0,0,0,0));
        end
        op(0, 1, 1); chk("R9 tx start beats static", mk(5,2,1,0,1,0,0,0,1));
        op(0, 0, 1); chk("R9 static ends window",    mk(5,2,1,0,1,0,0,0,0));
        op(0, 1);    chk("R9 tx start",              mk(5,2,1,0,1,0,0,0,1));
        op(0);       chk("R5 no transfer while sending", mk(5,2,1,0,1,0,0,0,1));
        op(0,0,0,0,1); chk("R10 transmitted",        mk(5,2,1,0,1,1,0,0,0));
        op(0);       chk("R5 transfer after sent",   mk(5,2,1,0,1,1,0,1,0));
        op(0);       chk("R4 second swap",           mk(2,5,0,1,1,0,0,0,0));
        op(6);       chk("R11 clear again",          mk(2,5,0,0,1,0,0,0,0));

        // immediate mode
        mode_imm = 1;
        op(4); op(1); op(5);
        chk("R6 committed over unsent",         mk(2,5,1,0,1,0,0,0,0));
        op(0, 1);    chk("R8 transfer beats tx slot", mk(2,5,1,0,1,0,0,1,0));
        op(0);       chk("R6 immediate swap",        mk(5,2,0,1,1,0,0,0,0));
        op(4); op(1); op(5);
        chk("R7 setup",                         mk(5,2,1,1,1,0,0,0,0));
        op(2);       chk("R7 disable dropped",       mk(5,2,1,1,1,0,0,1,0));
        op(6);       chk("R11 set wins over clear",  mk(2,5,0,1,1,0,0,0,0));

        op(0, 1);    chk("R9 tx start imm",          mk(2,5,0,1,1,0,0,0,1));
        op(4); op(1); op(5);
        chk("R6 committed while busy",          mk(2,5,1,1,1,0,0,0,1));
        op(0);       chk("R6 no transfer while busy", mk(2,5,1,1,1,0,0,0,1));
        op(0,0,0,0,1); chk("R10 transmitted imm",    mk(2,5,1,1,1,1,0,0,0));
        op(0);       chk("R6 transfer after idle",   mk(2,5,1,1,1,1,0,1,0));
        op(0);       chk("R4 swap imm",              mk(5,2,0,1,1,0,0,0,0));

        // disabled paths
        op(2);       chk("R2 disable",               mk(5,2,0,1,1,0,1,0,0));
        op(4);       chk("R2 disabled to dislocked", mk(5,2,0,1,1,0,2,0,0));
        op(1);       chk("R1 commit when dislocked", mk(5,2,1,1,1,0,2,0,0));
        op(5);       chk("R2 dislocked unlock",      mk(5,2,1,1,1,0,1,0,0));
        op(0);       chk("R3 no transfer when disabled", mk(5,2,1,1,1,0,1,0,0));
        op(3);       chk("R2 enable",                mk(5,2,1,1,1,0,0,0,0));
        op(0);       chk("R3 start after enable",    mk(5,2,1,1,1,0,0,1,0));
        op(0);       chk("R3 swap after enable",     mk(2,5,0,1,1,0,0,0,0));
        op(0, 1, 0, 1); chk("R9 tx start beats dynamic", mk(2,5,0,1,1,0,0,0,1));
        op(0, 0, 0, 1); chk("R9 dynamic ends window",    mk(2,5,0,1,1,0,0,0,0));

        @(negedge clk); #1;
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule